// File: doc/BRIEF.md
# Sleep Depth and Wake-up Clock Controller

This block decides which clocks of a small processor run. While the core runs, every gate enable is high. A one-cycle idle strobe moves the controller into one of three sleep depths: light, mid or deep. A two-bit control input chooses the depth. Each depth switches off a different set of clock domains. The core clock, the pulse-density output and the timer are gated. The PLL and the master peripheral clock are gated as well. A flag tells the interrupt capture logic whether to sample synchronously or asynchronously. Whether the timer keeps running in mid sleep depends on its clock source: half the master clock, or a reference oscillator.

An enabled interrupt ends sleep. A timer interrupt or an external-port interrupt counts as enabled only if its mask bit was set at the moment of the idle strobe. The controller samples both mask bits at that strobe and ignores later changes to them until the next idle. After a wake it passes through a settle phase. In that phase the core clock stays off while a down-counter runs out. The counter is loaded with one of two programmable reload values, one for the crystal oscillator and one for the trimmed RC oscillator. Light sleep keeps the oscillator running, so the settle phase after a light wake lasts one cycle. The asynchronous reset always leaves sleep at once, whatever the depth or the mask bits.

Top module: `slp_wake_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), the controller is in the run state at once, without waiting for a clock edge. Every gate enable (core_clk_en, pll_en, mclk_en, pdm_en, timer_en) is 1 and irq_async is 0. This holds whatever sleep depth was active and whatever the mask bits are.
- R2: In the run state, every gate enable is 1 and irq_async is 0.
- R3: An idle_strobe sampled high in the run state enters a sleep depth from the next edge on. depth_sel 2'b00 selects light sleep, 2'b01 mid sleep, and 2'b10 or 2'b11 deep sleep. core_clk_en is 0 in every sleep depth.
- R4: In light sleep, pll_en, mclk_en and timer_en are 1, pdm_en is 0 and irq_async is 0.
- R5: In mid sleep, pll_en, mclk_en and pdm_en are 0 and irq_async is 1. timer_en equals timer_src_osc, where 1 means the timer runs from a reference oscillator and 0 means it runs from half the master clock.
- R6: In deep sleep, all gate enables are 0 and irq_async is 1.
- R7: mask_tmr and mask_prt are sampled at the idle strobe. A sleep ends when timer_irq is high with the sampled mask_tmr set, or when port_irq is high with the sampled mask_prt set. Any other interrupt, and any change of a mask input during sleep, leaves the sleep depth unchanged.
- R8: On the wake edge, the settle counter loads a reload value. After a mid or deep wake it loads xtal_settle if osc_xtal is 1 at that edge, and rc_settle otherwise. After a light wake it loads 0. The counter then counts down once per cycle. With a loaded value N, core_clk_en stays 0 for N+1 cycles after the wake edge and is 1 from the next edge on.
- R9: During the settle phase, pll_en, mclk_en and timer_en are 1, pdm_en and core_clk_en are 0, and irq_async is 0.
- R10: An idle_strobe outside the run state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces run |
| idle_strobe | input | 1 | One-cycle idle request from the core |
| depth_sel | input | 2 | Sleep depth code: 00 light, 01 mid, 1x deep |
| mask_tmr | input | 1 | Timer interrupt mask bit, sampled at idle |
| mask_prt | input | 1 | External-port interrupt mask bit, sampled at idle |
| timer_irq | input | 1 | Timer interrupt request |
| port_irq | input | 1 | External-port interrupt request |
| timer_src_osc | input | 1 | Timer clock source: 1 reference oscillator, 0 half master clock |
| osc_xtal | input | 1 | Selected oscillator: 1 crystal, 0 RC |
| xtal_settle | input | CNT_W | Settle reload value for the crystal oscillator |
| rc_settle | input | CNT_W | Settle reload value for the RC oscillator |
| core_clk_en | output | 1 | Core clock gate enable |
| pll_en | output | 1 | PLL enable |
| mclk_en | output | 1 | Master peripheral clock gate enable |
| pdm_en | output | 1 | Pulse-density output clock enable |
| timer_en | output | 1 | Timer clock gate enable |
| irq_async | output | 1 | 1 selects asynchronous interrupt capture |

## Verification
The bench builds the block with CNT_W set to 6. The reload values stay at most 63, so the full settle phase after every wake can be counted edge by edge. The bench drives a short crystal value of 9 and an RC value of 3. The crystal value is longer, as on real parts, and the two differ so that a swap of the oscillator selection shows up. The reload extremes 0 and 63 are also driven directly. A reload of 0 gives the same one-cycle settle as a light wake, and a reload of 63 reaches the top of the counter's range.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_LIGHT = 3'd1,
    ST_MID   = 3'd2,
    ST_DEEP  = 3'd3,
    ST_WAKE  = 3'd4
  } slp_state_e;

  typedef struct packed {
    logic core;
    logic pll;
    logic mclk;
    logic pdm;
    logic tmr;
    logic async_irq;
  } gate_t;

  localparam logic [1:0] DEPTH_LIGHT = 2'b00;
  localparam logic [1:0] DEPTH_MID   = 2'b01;
endpackage

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_strobe,
  input  logic [1:0] depth_sel,
  input  logic       mask_tmr,
  input  logic       mask_prt,
  input  logic       timer_irq,
  input  logic       port_irq,
  input  logic       settle_done,
  output slp_state_e state,
  output logic       wake_load,
  output logic       wake_light,
  output logic       m_tmr_q,
  output logic       m_prt_q
);
  slp_state_e state_nx;
  logic       asleep;
  logic       wake_hit;

  assign asleep   = (state == ST_LIGHT) || (state == ST_MID) || (state == ST_DEEP);
  assign wake_hit = (timer_irq && m_tmr_q) || (port_irq && m_prt_q);
  assign wake_load  = asleep && wake_hit;
  assign wake_light = (state == ST_LIGHT);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN: begin
        if (idle_strobe) begin
          if (depth_sel == DEPTH_LIGHT)    state_nx = ST_LIGHT;
          else if (depth_sel == DEPTH_MID) state_nx = ST_MID;
          else                             state_nx = ST_DEEP;
        end
      end
      ST_LIGHT, ST_MID, ST_DEEP: begin
        if (wake_hit) state_nx = ST_WAKE;
      end
      ST_WAKE: begin
        if (settle_done) state_nx = ST_RUN;
      end
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      m_tmr_q <= 1'b0;
      m_prt_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_RUN && idle_strobe) begin
        m_tmr_q <= mask_tmr;
        m_prt_q <= mask_prt;
      end
    end
  end
endmodule

// File: rtl/slp_settle_cnt.sv
module slp_settle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_zero,
  input  logic             count_en,
  input  logic             osc_xtal,
  input  logic [CNT_W-1:0] xtal_settle,
  input  logic [CNT_W-1:0] rc_settle,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] reload;

  always_comb begin
    if (load_zero)     reload = CNT_ZERO;
    else if (osc_xtal) reload = xtal_settle;
    else               reload = rc_settle;
  end

  assign done = (cnt == CNT_ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_ZERO;
    end else if (load) begin
      cnt <= reload;
    end else if (count_en && !done) begin
      cnt <= cnt - CNT_ONE;
    end
  end
endmodule

// File: rtl/slp_gate_dec.sv
module slp_gate_dec
  import slp_pkg::*;
(
  input  slp_state_e state,
  input  logic       timer_src_osc,
  output gate_t      gates
);
  always_comb begin
    gates = '{core: 1'b1, pll: 1'b1, mclk: 1'b1, pdm: 1'b1, tmr: 1'b1, async_irq: 1'b0};
    unique case (state)
      ST_RUN: ;
      ST_LIGHT: begin
        gates.core = 1'b0;
        gates.pdm  = 1'b0;
      end
      ST_MID: begin
        gates = '{core: 1'b0, pll: 1'b0, mclk: 1'b0, pdm: 1'b0,
                  tmr: timer_src_osc, async_irq: 1'b1};
      end
      ST_DEEP: begin
        gates = '{core: 1'b0, pll: 1'b0, mclk: 1'b0, pdm: 1'b0,
                  tmr: 1'b0, async_irq: 1'b1};
      end
      ST_WAKE: begin
        gates.core = 1'b0;
        gates.pdm  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_strobe,
  input  logic [1:0]       depth_sel,
  input  logic             mask_tmr,
  input  logic             mask_prt,
  input  logic             timer_irq,
  input  logic             port_irq,
  input  logic             timer_src_osc,
  input  logic             osc_xtal,
  input  logic [CNT_W-1:0] xtal_settle,
  input  logic [CNT_W-1:0] rc_settle,
  output logic             core_clk_en,
  output logic             pll_en,
  output logic             mclk_en,
  output logic             pdm_en,
  output logic             timer_en,
  output logic             irq_async
);
  slp_state_e       state;
  logic             wake_load;
  logic             wake_light;
  logic             m_tmr_q;
  logic             m_prt_q;
  logic             settle_done;
  logic [CNT_W-1:0] settle_cnt;
  gate_t            gates;

  slp_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_strobe(idle_strobe),
    .depth_sel  (depth_sel),
    .mask_tmr   (mask_tmr),
    .mask_prt   (mask_prt),
    .timer_irq  (timer_irq),
    .port_irq   (port_irq),
    .settle_done(settle_done),
    .state      (state),
    .wake_load  (wake_load),
    .wake_light (wake_light),
    .m_tmr_q    (m_tmr_q),
    .m_prt_q    (m_prt_q)
  );

  slp_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wake_load),
    .load_zero  (wake_light),
    .count_en   (state == ST_WAKE),
    .osc_xtal   (osc_xtal),
    .xtal_settle(xtal_settle),
    .rc_settle  (rc_settle),
    .cnt        (settle_cnt),
    .done       (settle_done)
  );

  slp_gate_dec u_dec (
    .state        (state),
    .timer_src_osc(timer_src_osc),
    .gates        (gates)
  );

  assign core_clk_en = gates.core;
  assign pll_en      = gates.pll;
  assign mclk_en     = gates.mclk;
  assign pdm_en      = gates.pdm;
  assign timer_en    = gates.tmr;
  assign irq_async   = gates.async_irq;
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_strobe,
  input logic             timer_irq,
  input logic             port_irq,
  input logic             m_tmr_q,
  input logic             m_prt_q,
  input logic [CNT_W-1:0] settle_cnt,
  input logic             core_clk_en,
  input logic             pll_en,
  input logic             mclk_en,
  input logic             pdm_en,
  input logic             timer_en,
  input logic             irq_async
);
  // R3: an idle request while running stops the core clock on the next edge
  p_idle_stops_core_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && idle_strobe) |=> !core_clk_en);

  // R7: mid/deep sleep persists while no enabled interrupt is present
  p_masked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en && !(timer_irq && m_tmr_q) && !(port_irq && m_prt_q)) |=> !pll_en);

  // R8: the core clock returns only after the settle count reached zero
  p_settle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> ($past(settle_cnt) == '0));

  // R9: leaving mid/deep sleep always enters the settle phase, not run
  p_wake_via_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> !core_clk_en);

  // R6: with the timer clock gated off, the PLL is off as well
  p_timer_off_deep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_en |-> (!pll_en && !mclk_en && irq_async));

  // R2: pulse-density output runs only together with the core
  p_pdm_with_core_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pdm_en |-> (core_clk_en && !irq_async));
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idle_strobe(idle_strobe),
  .timer_irq  (timer_irq),
  .port_irq   (port_irq),
  .m_tmr_q    (m_tmr_q),
  .m_prt_q    (m_prt_q),
  .settle_cnt (settle_cnt),
  .core_clk_en(core_clk_en),
  .pll_en     (pll_en),
  .mclk_en    (mclk_en),
  .pdm_en     (pdm_en),
  .timer_en   (timer_en),
  .irq_async  (irq_async)
);

// File: tb/slp_wake_ctrl_bench.sv
module slp_wake_ctrl_bench;
  localparam int CNT_W = 6;
  localparam int DEPTH_L = 0;
  localparam int DEPTH_M = 1;
  localparam int DEPTH_D = 2;
  localparam int DEPTH_W = 3; // settle phase
  localparam int DEPTH_R = 4; // run

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_strobe = 1'b0;
  logic [1:0] depth_sel = 2'b00;
  logic mask_tmr = 1'b0, mask_prt = 1'b0;
  logic timer_irq = 1'b0, port_irq = 1'b0;
  logic timer_src_osc = 1'b0, osc_xtal = 1'b0;
  logic [CNT_W-1:0] xtal_settle = 6'd9;
  logic [CNT_W-1:0] rc_settle = 6'd3;
  logic core_clk_en, pll_en, mclk_en, pdm_en, timer_en, irq_async;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  slp_wake_ctrl #(.CNT_W(CNT_W)) u_slp_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .idle_strobe(idle_strobe), .depth_sel(depth_sel),
    .mask_tmr(mask_tmr), .mask_prt(mask_prt), .timer_irq(timer_irq), .port_irq(port_irq),
    .timer_src_osc(timer_src_osc), .osc_xtal(osc_xtal), .xtal_settle(xtal_settle),
    .rc_settle(rc_settle), .core_clk_en(core_clk_en), .pll_en(pll_en), .mclk_en(mclk_en),
    .pdm_en(pdm_en), .timer_en(timer_en), .irq_async(irq_async)
  );

  // expected {core,pll,mclk,pdm,timer,async} for a bench mode
  function automatic logic [5:0] exp_gates(int mode, logic src_osc);
    case (mode)
      DEPTH_L: return 6'b011010;
      DEPTH_M: return {5'b00000, 1'b0} | {4'b0000, src_osc, 1'b1};
      DEPTH_D: return 6'b000001;
      DEPTH_W: return 6'b011010;
      default: return 6'b111110;
    endcase
  endfunction

  function automatic int depth_mode(logic [1:0] code);
    if (code == 2'b00) return DEPTH_L;
    if (code == 2'b01) return DEPTH_M;
    return DEPTH_D;
  endfunction

  task automatic check_gates(int mode, string req);
    logic [5:0] act, exp;
    act = {core_clk_en, pll_en, mclk_en, pdm_en, timer_en, irq_async};
    exp = exp_gates(mode, timer_src_osc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gates actual %b expected %b (mode %0d)", req, act, exp, mode);
    end
  endtask

  task automatic check_bit(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // drive a one-cycle idle strobe; returns at the negedge after the edge
  task automatic do_idle(logic [1:0] code, logic mt, logic mp);
    depth_sel = code; mask_tmr = mt; mask_prt = mp; idle_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    idle_strobe = 1'b0;
  endtask

  // pulse interrupts for one cycle; returns at the negedge after the edge
  task automatic pulse_irq(logic ti, logic pi);
    timer_irq = ti; port_irq = pi;
    @(posedge clk); @(negedge clk);
    timer_irq = 1'b0; port_irq = 1'b0;
  endtask

  // after a wake edge: expect exactly n+1 settle samples, then run (R8, R9)
  task automatic check_settle(int n);
    for (int k = 0; k <= n; k++) begin
      check_gates(DEPTH_W, "R9");
      @(posedge clk); @(negedge clk);
    end
    check_bit(core_clk_en, 1'b1, "R8 core back after settle");
    check_gates(DEPTH_R, "R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    check_gates(DEPTH_R, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_gates(DEPTH_R, "R2 after reset");

    // R4 light sleep, wake by timer, settle one cycle
    timer_src_osc = 1'b0;
    do_idle(2'b00, 1'b1, 1'b0);
    check_gates(DEPTH_L, "R4");
    pulse_irq(1'b1, 1'b0);
    check_settle(0);

    // R5 mid sleep with each timer source, wake via port, RC settle
    timer_src_osc = 1'b1;
    do_idle(2'b01, 1'b0, 1'b1);
    check_gates(DEPTH_M, "R5 osc source");
    timer_src_osc = 1'b0;
    #1 check_gates(DEPTH_M, "R5 half-clock source");
    osc_xtal = 1'b0;
    pulse_irq(1'b0, 1'b1);
    check_settle(3);

    // R6 deep (code 11), crystal settle
    do_idle(2'b11, 1'b1, 1'b1);
    check_gates(DEPTH_D, "R6");
    // R10 idle during sleep ignored
    do_idle(2'b00, 1'b1, 1'b1);
    check_gates(DEPTH_D, "R10 idle in sleep");
    osc_xtal = 1'b1;
    pulse_irq(1'b1, 1'b0);
    // R10 idle during settle ignored
    idle_strobe = 1'b1; depth_sel = 2'b10;
    check_gates(DEPTH_W, "R9");
    @(posedge clk); @(negedge clk);
    idle_strobe = 1'b0;
    check_settle(8);

    // R7 mask clear at idle, set during sleep: no wake
    do_idle(2'b10, 1'b0, 1'b0);
    mask_tmr = 1'b1; mask_prt = 1'b1;
    pulse_irq(1'b1, 1'b1);
    check_gates(DEPTH_D, "R7 mask set after idle ignored");
    // R1 reset exits deep sleep immediately
    rst_n = 1'b0;
    #1 check_gates(DEPTH_R, "R1 reset wakes deep");
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check_gates(DEPTH_R, "R1 run after reset");

    // R7 only the enabled source wakes
    do_idle(2'b01, 1'b0, 1'b1);
    pulse_irq(1'b1, 1'b0);
    check_gates(DEPTH_M, "R7 unmasked timer ignored");
    mask_prt = 1'b0;
    osc_xtal = 1'b0;
    pulse_irq(1'b0, 1'b1);
    check_settle(3);

    // R8 reload extremes 0 and 63
    rc_settle = 6'd0;
    do_idle(2'b10, 1'b1, 1'b0);
    pulse_irq(1'b1, 1'b0);
    check_settle(0);
    xtal_settle = 6'd63; osc_xtal = 1'b1;
    do_idle(2'b01, 1'b1, 1'b0);
    pulse_irq(1'b1, 1'b0);
    check_settle(63);
    rc_settle = 6'd3; xtal_settle = 6'd9;

    // constrained random rounds
    for (int r = 0; r < 60; r++) begin
      logic [1:0] code;
      logic mt, mp, ti, pi, wake;
      int mode;
      code = 2'($urandom_range(0, 3));
      mt = 1'($urandom); mp = 1'($urandom);
      timer_src_osc = 1'($urandom);
      mode = depth_mode(code);
      do_idle(code, mt, mp);
      check_gates(mode, "R3 random depth");
      mask_tmr = 1'($urandom); mask_prt = 1'($urandom);
      wake = 1'b0;
      for (int t = 0; t < 6 && !wake; t++) begin
        ti = 1'($urandom); pi = 1'($urandom);
        osc_xtal = 1'($urandom);
        wake = (ti && mt) || (pi && mp);
        pulse_irq(ti, pi);
        if (!wake) check_gates(mode, "R7 random no wake");
      end
      if (wake) begin
        if (mode == DEPTH_L) check_settle(0);
        else check_settle(osc_xtal ? 9 : 3);
      end else begin
        rst_n = 1'b0;
        #1 check_gates(DEPTH_R, "R1 random reset");
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule